// File: doc/BRIEF.md
# Ethernet bridge frame classifier

This block sits on the receive side of an Ethernet-to-bus bridge. It takes the received frame as a byte stream, one byte per clock, qualified by a valid strobe and marked by start-of-frame and end-of-frame flags. It checks the destination address and the encapsulation. Only two kinds of frame pass. The first is a raw frame whose length/type field carries a length. The second is an IPv4 frame that carries UDP to the bridge port.

For a frame that passes, the block pulls out the 16-bit control word that sits in front of the embedded bus packet. It presents the control word's flags and the host's bus generation together with the frame kind. It then streams every byte that follows the control word. A frame that fails any check produces one drop pulse, and the rest of that frame is ignored.

The board address is six bytes. The first five are a fixed 40-bit prefix, FA-61-0E-13-94 by default. The last byte is the 4-bit board switch value, zero-extended to eight bits.

Top module: `bfc_frame_classifier`

## Requirements
- R1: A frame whose first six bytes equal FA,61,0E,13,94 followed by {4'h0, board_id_i} is accepted. With any other last byte, such as the value for a different switch setting, the frame is dropped.
- R2: A destination of six 0xFF bytes is accepted as broadcast. Any destination that is neither broadcast nor the board address gives one drop_o pulse, one cycle after byte 5, and no further output for that frame.
- R3: A length/type value (bytes 12 and 13, big-endian) of 1500 or less marks a raw frame. kind_o is then 1, and the control word is taken from bytes 14 and 15.
- R4: A type value of 0x0800 marks a UDP frame (kind_o = 2) when three fields match: byte 14 is 0x45, byte 23 is 17, and bytes 36 and 37 hold destination port 1394 (0x05, 0x72). The control word is then taken from bytes 42 and 43.
- R5: An IPv4 frame with a different byte 14, a different protocol byte or a different destination port is dropped. The drop_o pulse comes one cycle after the offending byte.
- R6: Length/type values from 1501 to 1535, and type values other than 0x0800 (for example 0x0806), are dropped. The drop_o pulse comes one cycle after byte 13.
- R7: hdr_valid_o pulses for one cycle, one cycle after the second control byte. kind_o, no_fwd_o, flag_err_o and host_gen_o are loaded in that same cycle and hold until the next pulse. no_fwd_o is bit 0 of the first control byte. flag_err_o is set when any of that byte's bits 7..1 is set. host_gen_o is the second control byte.
- R8: Every byte after the control word appears on pay_data_o with pay_valid_o, one cycle after it is received. pay_last_o marks the byte received with rx_eof_i.
- R9: An end-of-frame before the second control byte gives one drop_o pulse. An end-of-frame on the second control byte gives hdr_valid_o and no payload. A start-of-frame in the middle of a frame abandons the old frame without a pulse.
- R10: After reset, all outputs are zero.
- R11: Cycles with rx_valid_i low neither advance the byte position nor cause output. Valid bytes outside a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte strobe |
| rx_sof_i | input | 1 | First byte of a frame (with rx_valid_i) |
| rx_eof_i | input | 1 | Last byte of a frame (with rx_valid_i) |
| rx_data_i | input | 8 | Received byte |
| board_id_i | input | 4 | Board switch value, low byte of the board address |
| hdr_valid_o | output | 1 | Control word captured for an accepted frame |
| kind_o | output | 2 | 1 raw, 2 UDP, 0 none yet |
| no_fwd_o | output | 1 | Keep-local flag from the control word |
| flag_err_o | output | 1 | Reserved control flag bit set |
| host_gen_o | output | 8 | Host bus generation from the control word |
| pay_valid_o | output | 1 | Payload byte strobe |
| pay_data_o | output | 8 | Payload byte |
| pay_last_o | output | 1 | Last payload byte of the frame |
| drop_o | output | 1 | Frame rejected or truncated |

## Verification
The assertions take the input stream to be well formed. rx_sof_i and rx_eof_i are only meaningful together with rx_valid_i, and board_id_i stays constant while a frame is in flight. The stimulus asserts the markers only on valid beats. It changes the switch value only between frames and inserts idle gaps only between bytes. The checks that are sensitive to ordering therefore see one event per beat at most, and always in the order the frame defines.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [1:0] {KIND_NONE = 2'd0, KIND_RAW = 2'd1, KIND_UDP = 2'd2} kind_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_IPH, ST_CTRL0, ST_CTRL1, ST_PAY, ST_DROP
  } st_e;

  localparam int EthHdrLen  = 14;
  localparam int IpHdrLen   = 20;
  localparam int UdpHdrLen  = 8;
  localparam int OffTypeHi  = 12;
  localparam int OffTypeLo  = 13;
  localparam int OffIpVihl  = EthHdrLen;
  localparam int OffIpProto = EthHdrLen + 9;
  localparam int OffUdpDpHi = EthHdrLen + IpHdrLen + 2;
  localparam int OffUdpDpLo = OffUdpDpHi + 1;
  localparam int OffUdpEnd  = EthHdrLen + IpHdrLen + UdpHdrLen - 1;
  localparam logic [15:0] EtypeIpv4 = 16'h0800;
  localparam logic [7:0]  IpVihl20  = 8'h45;
endpackage

// File: rtl/bfc_pos_counter.sv
module bfc_pos_counter #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sof_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IdxMax = '1;
  localparam logic [IDX_W-1:0] IdxOne = IDX_W'(1);

  logic [IDX_W-1:0] cnt_q;

  assign idx_o = sof_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (beat_i) cnt_q <= (idx_o == IdxMax) ? idx_o : idx_o + IdxOne;
  end

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_i |=> $stable(cnt_q));
endmodule

// File: rtl/bfc_mac_match.sv
module bfc_mac_match #(
  parameter int                  IDX_W    = 6,
  parameter int                  SW_W     = 4,
  parameter int                  PREFIX_W = 40,
  parameter logic [PREFIX_W-1:0] PREFIX   = 40'hFA610E1394
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  input  logic [SW_W-1:0]  board_i,
  output logic             mac_ok_o
);
  localparam int NB = PREFIX_W / 8;
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NB);

  logic [7:0] exp_tab [NB+1];
  logic [7:0] exp_byte;
  logic       own_q, bc_q, own_d, bc_d, first;

  for (genvar g = 0; g < NB; g++) begin : g_prefix
    assign exp_tab[g] = PREFIX[PREFIX_W-1-8*g -: 8];
  end
  assign exp_tab[NB] = {{(8-SW_W){1'b0}}, board_i};

  always_comb begin
    exp_byte = '0;
    for (int k = 0; k <= NB; k++)
      if (idx_i == IDX_W'(k)) exp_byte = exp_tab[k];
  end

  assign first    = (idx_i == '0);
  assign own_d    = (first | own_q) & (byte_i == exp_byte);
  assign bc_d     = (first | bc_q)  & (byte_i == 8'hFF);
  assign mac_ok_o = own_d | bc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= 1'b0;
      bc_q  <= 1'b0;
    end else if (beat_i && idx_i <= LastIdx) begin
      own_q <= own_d;
      bc_q  <= bc_d;
    end
  end

  // prefix starts with a byte other than 0xFF, so both paths cannot survive
  assert_mac_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(own_q && bc_q));
endmodule

// File: rtl/bfc_hdr_check.sv
module bfc_hdr_check #(
  parameter int          IDX_W    = 6,
  parameter logic [15:0] MAX_LEN  = 16'd1500,
  parameter logic [15:0] UDP_PORT = 16'd1394,
  parameter logic [7:0]  IP_PROTO = 8'd17
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  input  logic [7:0]       type_hi_i,
  output logic             len_raw_o,
  output logic             type_ipv4_o,
  output logic             ip_bad_o
);
  import bfc_pkg::*;
  localparam logic [IDX_W-1:0] IVihl  = IDX_W'(OffIpVihl);
  localparam logic [IDX_W-1:0] IProto = IDX_W'(OffIpProto);
  localparam logic [IDX_W-1:0] IDpHi  = IDX_W'(OffUdpDpHi);
  localparam logic [IDX_W-1:0] IDpLo  = IDX_W'(OffUdpDpLo);

  logic [15:0] lt;
  assign lt          = {type_hi_i, byte_i};
  assign len_raw_o   = (lt <= MAX_LEN);
  assign type_ipv4_o = (lt == EtypeIpv4);

  always_comb begin
    ip_bad_o = 1'b0;
    if      (idx_i == IVihl)  ip_bad_o = (byte_i != IpVihl20);
    else if (idx_i == IProto) ip_bad_o = (byte_i != IP_PROTO);
    else if (idx_i == IDpHi)  ip_bad_o = (byte_i != UDP_PORT[15:8]);
    else if (idx_i == IDpLo)  ip_bad_o = (byte_i != UDP_PORT[7:0]);
  end
endmodule

// File: rtl/bfc_frame_classifier.sv
module bfc_frame_classifier #(
  parameter int          IDX_W    = 6,
  parameter int          SW_W     = 4,
  parameter logic [39:0] PREFIX   = 40'hFA610E1394,
  parameter logic [15:0] MAX_LEN  = 16'd1500,
  parameter logic [15:0] UDP_PORT = 16'd1394,
  parameter logic [7:0]  IP_PROTO = 8'd17
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_valid_i,
  input  logic            rx_sof_i,
  input  logic            rx_eof_i,
  input  logic [7:0]      rx_data_i,
  input  logic [SW_W-1:0] board_id_i,
  output logic            hdr_valid_o,
  output logic [1:0]      kind_o,
  output logic            no_fwd_o,
  output logic            flag_err_o,
  output logic [7:0]      host_gen_o,
  output logic            pay_valid_o,
  output logic [7:0]      pay_data_o,
  output logic            pay_last_o,
  output logic            drop_o
);
  import bfc_pkg::*;
  localparam int PREFIX_W = 40;
  localparam logic [IDX_W-1:0] IMacLast = IDX_W'(PREFIX_W / 8);
  localparam logic [IDX_W-1:0] ITypeHi  = IDX_W'(OffTypeHi);
  localparam logic [IDX_W-1:0] ITypeLo  = IDX_W'(OffTypeLo);
  localparam logic [IDX_W-1:0] IUdpEnd  = IDX_W'(OffUdpEnd);

  logic [IDX_W-1:0] idx;
  logic             mac_ok, len_raw, type_ipv4, ip_bad;
  st_e              st_q, st_d, cur_st;
  kind_e            pend_q, pend_d;
  logic [7:0]       type_hi_q, type_hi_d, flags_q, flags_d;
  logic             hdr_d, pay_d, drop_d, hdr_seen_q;

  bfc_pos_counter #(.IDX_W(IDX_W)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .beat_i(rx_valid_i), .sof_i(rx_sof_i), .idx_o(idx)
  );

  bfc_mac_match #(.IDX_W(IDX_W), .SW_W(SW_W), .PREFIX_W(PREFIX_W), .PREFIX(PREFIX)) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .beat_i(rx_valid_i), .idx_i(idx),
    .byte_i(rx_data_i), .board_i(board_id_i), .mac_ok_o(mac_ok)
  );

  bfc_hdr_check #(.IDX_W(IDX_W), .MAX_LEN(MAX_LEN), .UDP_PORT(UDP_PORT),
                  .IP_PROTO(IP_PROTO)) u_hdr (
    .idx_i(idx), .byte_i(rx_data_i), .type_hi_i(type_hi_q),
    .len_raw_o(len_raw), .type_ipv4_o(type_ipv4), .ip_bad_o(ip_bad)
  );

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    type_hi_d = type_hi_q;
    flags_d   = flags_q;
    hdr_d     = 1'b0;
    pay_d     = 1'b0;
    drop_d    = 1'b0;
    cur_st    = rx_sof_i ? ST_HDR : st_q;
    if (rx_valid_i) begin
      st_d = cur_st;
      unique case (cur_st)
        ST_HDR: begin
          if (idx == IMacLast && !mac_ok) begin
            st_d = ST_DROP; drop_d = 1'b1;
          end else if (idx == ITypeHi) begin
            type_hi_d = rx_data_i;
          end else if (idx == ITypeLo) begin
            if (len_raw)        begin pend_d = KIND_RAW; st_d = ST_CTRL0; end
            else if (type_ipv4) begin pend_d = KIND_UDP; st_d = ST_IPH;   end
            else                begin st_d = ST_DROP; drop_d = 1'b1;      end
          end
        end
        ST_IPH: begin
          if (ip_bad)               begin st_d = ST_DROP; drop_d = 1'b1; end
          else if (idx == IUdpEnd)  st_d = ST_CTRL0;
        end
        ST_CTRL0: begin flags_d = rx_data_i; st_d = ST_CTRL1; end
        ST_CTRL1: begin hdr_d = 1'b1; st_d = ST_PAY; end
        ST_PAY:   pay_d = 1'b1;
        default: ;
      endcase
      if (rx_eof_i) begin
        // frame ended while still undecided
        if (st_d inside {ST_HDR, ST_IPH, ST_CTRL0, ST_CTRL1}) drop_d = 1'b1;
        st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pend_q      <= KIND_NONE;
      type_hi_q   <= '0;
      flags_q     <= '0;
      hdr_valid_o <= 1'b0;
      kind_o      <= '0;
      no_fwd_o    <= 1'b0;
      flag_err_o  <= 1'b0;
      host_gen_o  <= '0;
      pay_valid_o <= 1'b0;
      pay_data_o  <= '0;
      pay_last_o  <= 1'b0;
      drop_o      <= 1'b0;
      hdr_seen_q  <= 1'b0;
    end else begin
      st_q        <= st_d;
      pend_q      <= pend_d;
      type_hi_q   <= type_hi_d;
      flags_q     <= flags_d;
      hdr_valid_o <= hdr_d;
      pay_valid_o <= pay_d;
      pay_last_o  <= pay_d & rx_eof_i;
      drop_o      <= drop_d;
      if (pay_d) pay_data_o <= rx_data_i;
      if (hdr_d) begin
        kind_o     <= pend_q;
        no_fwd_o   <= flags_q[0];
        flag_err_o <= |flags_q[7:1];
        host_gen_o <= rx_data_i;
      end
      if (rx_valid_i && rx_sof_i) hdr_seen_q <= 1'b0;
      else if (hdr_d)             hdr_seen_q <= 1'b1;
    end
  end

  assert_one_event_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hdr_valid_o, pay_valid_o, drop_o}));
  assert_kind_known_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> kind_o != KIND_NONE);
  assert_fields_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_valid_o |-> $stable(host_gen_o) && $stable(kind_o) && $stable(no_fwd_o));
  assert_pay_after_hdr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_o |-> hdr_seen_q);
  assert_last_is_pay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_last_o |-> pay_valid_o);
endmodule

// File: tb/bfc_frame_classifier_bench.sv
`timescale 1ns/1ps
module bfc_frame_classifier_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic [3:0] board = 4'h4;
  logic       hdr_valid, no_fwd, flag_err, pay_valid, pay_last, drop;
  logic [1:0] kind;
  logic [7:0] host_gen, pay_data;

  always #2.5 clk = ~clk;

  bfc_frame_classifier u_bfc_frame_classifier (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_data_i(rx_data), .board_id_i(board),
    .hdr_valid_o(hdr_valid), .kind_o(kind), .no_fwd_o(no_fwd), .flag_err_o(flag_err),
    .host_gen_o(host_gen), .pay_valid_o(pay_valid), .pay_data_o(pay_data),
    .pay_last_o(pay_last), .drop_o(drop)
  );

  int          n_chk = 0, n_bad = 0;
  bit          done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  fr[$];

  function automatic logic [15:0] ev_hdr(logic [1:0] k, logic [7:0] fl, logic [7:0] g);
    return {2'd1, k, fl[0], |fl[7:1], 2'b00, g};
  endfunction
  function automatic logic [15:0] ev_pay(logic last, logic [7:0] d);
    return {2'd2, 4'b0000, last, 1'b0, d};
  endfunction
  localparam logic [15:0] EvDrop = {2'd3, 14'd0};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each produced event against the scoreboard
  task automatic take(logic [15:0] act);
    if (exp_q.size() == 0) chk("R9 unexpected event", {16'd0, act}, 32'd0);
    else chk(tag_q.pop_front(), {16'd0, act}, {16'd0, exp_q.pop_front()});
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (hdr_valid) take(ev_hdr(kind, {7'd0, no_fwd} | {flag_err, 7'd0}, host_gen));
      if (pay_valid) take(ev_pay(pay_last, pay_data));
      if (drop)      take(EvDrop);
    end
  end

  task automatic exp_ok(string tag, logic [1:0] k, logic [7:0] fl, logic [7:0] g, int npay);
    exp_q.push_back(ev_hdr(k, fl, g)); tag_q.push_back(tag);
    for (int i = 0; i < npay; i++) begin
      exp_q.push_back(ev_pay(i == npay - 1, 8'hA0 + 8'(i))); tag_q.push_back(tag);
    end
  endtask
  task automatic exp_drop(string tag);
    exp_q.push_back(EvDrop); tag_q.push_back(tag);
  endtask

  function automatic logic [47:0] own_mac(logic [3:0] b);
    return {40'hFA610E1394, 4'h0, b};
  endfunction

  task automatic put_eth(logic [47:0] dst, logic [15:0] lt);
    fr = {};
    for (int i = 5; i >= 0; i--) fr.push_back(dst[8*i +: 8]);
    for (int i = 0; i < 6; i++)  fr.push_back(8'h02 + 8'(i));
    fr.push_back(lt[15:8]); fr.push_back(lt[7:0]);
  endtask
  task automatic put_ipudp(logic [7:0] vihl, logic [7:0] proto, logic [15:0] dport);
    fr.push_back(vihl); fr.push_back(8'h00);
    for (int i = 0; i < 6; i++) fr.push_back(8'h10 + 8'(i));
    fr.push_back(8'd64); fr.push_back(proto);
    for (int i = 0; i < 10; i++) fr.push_back(8'h20 + 8'(i));
    fr.push_back(8'h30); fr.push_back(8'h31);
    fr.push_back(dport[15:8]); fr.push_back(dport[7:0]);
    for (int i = 0; i < 4; i++) fr.push_back(8'h40 + 8'(i));
  endtask
  task automatic put_ctrl(logic [7:0] fl, logic [7:0] g, int npay);
    fr.push_back(fl); fr.push_back(g);
    for (int i = 0; i < npay; i++) fr.push_back(8'hA0 + 8'(i));
  endtask

  task automatic send(bit gaps, bit no_eof);
    for (int i = 0; i < fr.size(); i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0);
      rx_eof = !no_eof && (i == fr.size() - 1); rx_data = fr[i];
      if (gaps && (i % 4 == 2)) begin
        @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'hEE;
      end
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 reset outputs", {8'd0, hdr_valid, kind, no_fwd, flag_err, host_gen, pay_valid,
        pay_data, pay_last, drop}, 32'd0);

    // R1 R3: raw to own address
    put_eth(own_mac(4'h4), 16'd6); put_ctrl(8'h00, 8'h37, 4);
    exp_ok("R1 R3 raw own", 2'd1, 8'h00, 8'h37, 4); send(0, 0);
    // R2 R7: broadcast, keep-local flag, idle gaps (R11)
    put_eth(48'hFFFF_FFFF_FFFF, 16'd5); put_ctrl(8'h01, 8'h05, 3);
    exp_ok("R2 R7 R11 broadcast gaps", 2'd1, 8'h01, 8'h05, 3); send(1, 0);
    // R2: foreign address
    put_eth(own_mac(4'h5), 16'd5); put_ctrl(8'h00, 8'h11, 3);
    exp_drop("R2 foreign mac"); send(0, 0);
    // R1: new switch value
    board = 4'hA;
    put_eth(own_mac(4'hA), 16'd3); put_ctrl(8'h00, 8'h22, 1);
    exp_ok("R1 switch A", 2'd1, 8'h00, 8'h22, 1); send(0, 0);
    put_eth(own_mac(4'h4), 16'd3); put_ctrl(8'h00, 8'h22, 1);
    exp_drop("R1 old switch"); send(0, 0);
    // R4: UDP
    put_eth(own_mac(4'hA), 16'h0800); put_ipudp(8'h45, 8'd17, 16'd1394);
    put_ctrl(8'h01, 8'h80, 5);
    exp_ok("R4 udp", 2'd2, 8'h01, 8'h80, 5); send(1, 0);
    // R5
    put_eth(own_mac(4'hA), 16'h0800); put_ipudp(8'h45, 8'd6, 16'd1394); put_ctrl(0, 1, 2);
    exp_drop("R5 proto"); send(0, 0);
    put_eth(own_mac(4'hA), 16'h0800); put_ipudp(8'h45, 8'd17, 16'd1395); put_ctrl(0, 1, 2);
    exp_drop("R5 port"); send(0, 0);
    put_eth(48'hFFFF_FFFF_FFFF, 16'h0800); put_ipudp(8'h46, 8'd17, 16'd1394); put_ctrl(0, 1, 2);
    exp_drop("R5 ihl"); send(0, 0);
    // R6 and R3 boundary
    put_eth(own_mac(4'hA), 16'd1501); put_ctrl(0, 1, 2); exp_drop("R6 1501"); send(0, 0);
    put_eth(own_mac(4'hA), 16'd1535); put_ctrl(0, 1, 2); exp_drop("R6 1535"); send(0, 0);
    put_eth(own_mac(4'hA), 16'h0806); put_ctrl(0, 1, 2); exp_drop("R6 0806"); send(0, 0);
    put_eth(own_mac(4'hA), 16'd1500); put_ctrl(8'h00, 8'h44, 2);
    exp_ok("R3 len 1500", 2'd1, 8'h00, 8'h44, 2); send(0, 0);
    // R7 reserved flag bits
    put_eth(own_mac(4'hA), 16'd4); put_ctrl(8'h82, 8'h09, 2);
    exp_ok("R7 flag err", 2'd1, 8'h82, 8'h09, 2); send(0, 0);
    // R9 truncations
    put_eth(own_mac(4'hA), 16'd4); put_ctrl(0, 1, 2);
    while (fr.size() > 10) void'(fr.pop_back());
    exp_drop("R9 eof in header"); send(0, 0);
    put_eth(own_mac(4'hA), 16'd4); put_ctrl(8'h00, 8'h66, 0); void'(fr.pop_back());
    exp_drop("R9 eof on first ctrl byte"); send(0, 0);
    put_eth(own_mac(4'hA), 16'd4); put_ctrl(8'h01, 8'h66, 0);
    exp_ok("R9 eof on second ctrl byte", 2'd1, 8'h01, 8'h66, 0); send(0, 0);
    // R9 restart mid-frame
    put_eth(own_mac(4'hA), 16'd4); while (fr.size() > 8) void'(fr.pop_back());
    send(0, 1);
    put_eth(own_mac(4'hA), 16'd4); put_ctrl(8'h00, 8'h77, 2);
    exp_ok("R9 restart", 2'd1, 8'h00, 8'h77, 2); send(0, 0);
    // R11 stray bytes outside a frame
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 3); rx_data = 8'hFF;
    end
    @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 stray bytes no output", {31'd0, hdr_valid | pay_valid | drop}, 32'd0);
    chk("R7 fields held", {22'd0, kind, host_gen}, {22'd0, 2'd1, 8'h77});

    repeat (5) @(negedge clk);
    chk("R8 scoreboard drained", exp_q.size(), 32'd0);
    done = 1;
    report();
  end
endmodule